// File: doc/BRIEF.md
# Programmable Link Synchronization Tracker

This block follows a comma-based word aligner on the receive side of an 8b/10b serial link. For each received word it gets three indications: a word is present, the word is a valid synchronization code group, and the word is a code group error. From these it drives one registered status bit that tells downstream logic whether the link is synchronized or has lost synchronization. The block assumes 8b/10b-encoded input, so the error and sync-group flags mean something. It does not decode, detect commas or shift bits.

Three counts control its behaviour:
- **Acquire count** (1 to 256): valid sync groups needed to gain lock.
- **Loss count** (1 to 256): accumulated errors that drop lock.
- **Forgiveness run** (1 to 64): consecutive good words that cancel one accumulated error.

These counts come from static configuration inputs, or from one of four fixed preset sets chosen by the `MODE` parameter. The presets, written as acquire / loss / run, are:
- PCIe-style: 4/17/16
- XAUI-style: 4/4/4
- gigabit-Ethernet-style: 3/4/4
- Serial-RapidIO-style: 127/255/3

Error tolerance is leaky. Errors accumulate. A full run of consecutive good words pays one error back. Lock drops only when the accumulated count reaches the loss count.

Top module: `link_sync_tracker`

## Requirements
- R1: While `rst_n` is low, and after it is released until acquisition completes, `sync_ok` is 0 (0 = hunting, 1 = locked).
- R2: While hunting, `sync_ok` rises on the clock edge that samples the N-th valid sync group, where N = `cfg_acq_m1` + 1 (1 to 256). A valid sync group is `word_vld`=1, `sync_grp`=1, `code_err`=0. Cycles with `word_vld`=0 change nothing.
- R3: While hunting, any errored word restarts the acquire count from zero. This includes a word with both `sync_grp` and `code_err` set. A present word that is neither errored nor a sync group holds the count.
- R4: While locked, `sync_ok` falls on the clock edge that samples the errored word bringing the accumulated error count to M, where M = `cfg_lose_m1` + 1 (1 to 256).
- R5: While locked, every K consecutive non-errored words (K = `cfg_run_m1` + 1, 1 to 64) reduce the accumulated error count by one.
  - An errored word restarts the run.
  - Each reduction also restarts the run.
  - The error count never goes below zero.
- R6: After lock is lost, all counters are cleared, and `sync_ok` stays 0 until a full N valid sync groups have been received again.
- R7: With `MODE` 1/2/3/4, the fixed sets (acquire/loss/run) are used and the configuration inputs are ignored. The sets are 1 = 4/17/16, 2 = 4/4/4, 3 = 3/4/4, 4 = 127/255/3. `MODE` 0 takes the counts from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous receive reset, active low |
| cfg_acq_m1 | input | 8 | Acquire count minus one (static) |
| cfg_lose_m1 | input | 8 | Loss error count minus one (static) |
| cfg_run_m1 | input | 6 | Forgiveness run length minus one (static) |
| word_vld | input | 1 | A word is present this cycle |
| sync_grp | input | 1 | The word is a valid synchronization code group |
| code_err | input | 1 | The word is an errored code group |
| sync_ok | output | 1 | 1 = synchronized, 0 = hunting |

## Verification
Every result of this block is due exactly one clock edge after the word that causes it. `sync_ok` reflects the word sampled at the previous rising edge: a lock, a loss, or no change at all. The driver applies each word at a falling edge and queues the expected `sync_ok` value, stamped with the cycle number after the next rising edge. The monitor compares each entry at the falling edge of that cycle, so every sample lands mid-cycle, one edge after its stimulus. Reset checks are made directly at a falling edge while reset is held.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

   typedef enum logic {
      ST_HUNT   = 1'b0,
      ST_LOCKED = 1'b1
   } lsync_state_e;

   localparam int MODE_PORTS = 0;
   localparam int MODE_PCIE  = 1;
   localparam int MODE_XAUI  = 2;
   localparam int MODE_GIGE  = 3;
   localparam int MODE_SRIO  = 4;

   function automatic int preset_acq(int mode);
      case (mode)
         MODE_PCIE: return 4;
         MODE_XAUI: return 4;
         MODE_GIGE: return 3;
         MODE_SRIO: return 127;
         default:   return 1;
      endcase
   endfunction

   function automatic int preset_lose(int mode);
      case (mode)
         MODE_PCIE: return 17;
         MODE_XAUI: return 4;
         MODE_GIGE: return 4;
         MODE_SRIO: return 255;
         default:   return 1;
      endcase
   endfunction

   function automatic int preset_run(int mode);
      case (mode)
         MODE_PCIE: return 16;
         MODE_XAUI: return 4;
         MODE_GIGE: return 4;
         MODE_SRIO: return 3;
         default:   return 1;
      endcase
   endfunction

endpackage

// File: rtl/lsync_thresholds.sv
module lsync_thresholds
   import lsync_pkg::*;
#(
   parameter int MODE  = MODE_PORTS,
   parameter int ACQ_W = 8,
   parameter int ERR_W = 8,
   parameter int RUN_W = 6
) (
   input  logic [ACQ_W-1:0] cfg_acq_m1,
   input  logic [ERR_W-1:0] cfg_lose_m1,
   input  logic [RUN_W-1:0] cfg_run_m1,
   output logic [ACQ_W-1:0] acq_lim,
   output logic [ERR_W-1:0] lose_lim,
   output logic [RUN_W-1:0] run_lim
);

   generate
      if (MODE == MODE_PORTS) begin : g_ports
         assign acq_lim  = cfg_acq_m1;
         assign lose_lim = cfg_lose_m1;
         assign run_lim  = cfg_run_m1;
      end else begin : g_preset
         if (MODE < MODE_PCIE || MODE > MODE_SRIO) begin : g_bad_mode
            $error("lsync_thresholds: unknown MODE");
         end
         if (preset_acq(MODE) > (1 << ACQ_W)) begin : g_bad_acq
            $error("lsync_thresholds: preset acquire count exceeds ACQ_W");
         end
         if (preset_lose(MODE) > (1 << ERR_W)) begin : g_bad_lose
            $error("lsync_thresholds: preset loss count exceeds ERR_W");
         end
         if (preset_run(MODE) > (1 << RUN_W)) begin : g_bad_run
            $error("lsync_thresholds: preset run length exceeds RUN_W");
         end
         logic unused_cfg;
         assign unused_cfg = ^{cfg_acq_m1, cfg_lose_m1, cfg_run_m1};
         assign acq_lim  = ACQ_W'(preset_acq(MODE) - 1);
         assign lose_lim = ERR_W'(preset_lose(MODE) - 1);
         assign run_lim  = RUN_W'(preset_run(MODE) - 1);
      end
   endgenerate

endmodule

// File: rtl/lsync_acquire.sv
module lsync_acquire #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         tick,
   input  logic         bad,
   input  logic [W-1:0] limit,
   output logic         done,
   output logic [W-1:0] count
);

   // A sync group that is also errored counts as an error only.
   always_comb done = tick && !bad && (count == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count <= '0;
      end else if (bad) begin
         count <= '0;
      end else if (done) begin
         count <= '0;
      end else if (tick) begin
         count <= count + W'(1);
      end
   end

endmodule

// File: rtl/lsync_tolerance.sv
module lsync_tolerance #(
   parameter int ERR_W = 8,
   parameter int RUN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             good,
   input  logic             bad,
   input  logic [ERR_W-1:0] lose_lim,
   input  logic [RUN_W-1:0] run_lim,
   output logic             drop,
   output logic [ERR_W-1:0] err_cnt,
   output logic [RUN_W-1:0] run_cnt
);

   logic run_full;

   always_comb begin
      drop     = bad && (err_cnt == lose_lim);
      run_full = good && (run_cnt == run_lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         err_cnt <= '0;
         run_cnt <= '0;
      end else if (bad) begin
         run_cnt <= '0;
         err_cnt <= drop ? '0 : err_cnt + ERR_W'(1);
      end else if (run_full) begin
         run_cnt <= '0;
         if (err_cnt != '0) begin
            err_cnt <= err_cnt - ERR_W'(1);
         end
      end else if (good) begin
         run_cnt <= run_cnt + RUN_W'(1);
      end
   end

endmodule

// File: rtl/link_sync_tracker.sv
module link_sync_tracker
   import lsync_pkg::*;
#(
   parameter int MODE     = MODE_PORTS,
   parameter int ACQ_MAX  = 256,
   parameter int LOSE_MAX = 256,
   parameter int RUN_MAX  = 64,
   localparam int ACQ_W   = $clog2(ACQ_MAX),
   localparam int ERR_W   = $clog2(LOSE_MAX),
   localparam int RUN_W   = $clog2(RUN_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACQ_W-1:0] cfg_acq_m1,
   input  logic [ERR_W-1:0] cfg_lose_m1,
   input  logic [RUN_W-1:0] cfg_run_m1,
   input  logic             word_vld,
   input  logic             sync_grp,
   input  logic             code_err,
   output logic             sync_ok
);

   generate
      if (ACQ_MAX < 2 || (ACQ_MAX & (ACQ_MAX - 1)) != 0) begin : g_bad_acq_max
         $error("link_sync_tracker: ACQ_MAX must be a power of two >= 2");
      end
      if (LOSE_MAX < 2 || (LOSE_MAX & (LOSE_MAX - 1)) != 0) begin : g_bad_lose_max
         $error("link_sync_tracker: LOSE_MAX must be a power of two >= 2");
      end
      if (RUN_MAX < 2 || (RUN_MAX & (RUN_MAX - 1)) != 0) begin : g_bad_run_max
         $error("link_sync_tracker: RUN_MAX must be a power of two >= 2");
      end
   endgenerate

   logic [ACQ_W-1:0] acq_lim;
   logic [ERR_W-1:0] lose_lim;
   logic [RUN_W-1:0] run_lim;
   logic [ACQ_W-1:0] acq_cnt;
   logic [ERR_W-1:0] err_cnt;
   logic [RUN_W-1:0] run_cnt;
   logic             acq_done;
   logic             lose_now;
   logic             w_bad;
   logic             w_good;
   logic             w_sync;
   lsync_state_e     state_q;
   lsync_state_e     state_d;

   always_comb begin
      w_bad  = word_vld && code_err;
      w_good = word_vld && !code_err;
      w_sync = word_vld && sync_grp;
   end

   lsync_thresholds #(
      .MODE  (MODE),
      .ACQ_W (ACQ_W),
      .ERR_W (ERR_W),
      .RUN_W (RUN_W)
   ) u_thr (
      .cfg_acq_m1  (cfg_acq_m1),
      .cfg_lose_m1 (cfg_lose_m1),
      .cfg_run_m1  (cfg_run_m1),
      .acq_lim     (acq_lim),
      .lose_lim    (lose_lim),
      .run_lim     (run_lim)
   );

   lsync_acquire #(
      .W (ACQ_W)
   ) u_acq (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_LOCKED),
      .tick  (w_sync),
      .bad   (w_bad),
      .limit (acq_lim),
      .done  (acq_done),
      .count (acq_cnt)
   );

   lsync_tolerance #(
      .ERR_W (ERR_W),
      .RUN_W (RUN_W)
   ) u_tol (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state_q == ST_HUNT),
      .good     (w_good),
      .bad      (w_bad),
      .lose_lim (lose_lim),
      .run_lim  (run_lim),
      .drop     (lose_now),
      .err_cnt  (err_cnt),
      .run_cnt  (run_cnt)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_HUNT:   if (acq_done) state_d = ST_LOCKED;
         ST_LOCKED: if (lose_now) state_d = ST_HUNT;
         default:   state_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
      end else begin
         state_q <= state_d;
      end
   end

   assign sync_ok = (state_q == ST_LOCKED);

endmodule

// File: rtl/lsync_checker.sv
module lsync_checker #(
   parameter int ACQ_W = 8,
   parameter int ERR_W = 8,
   parameter int RUN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             word_vld,
   input logic             sync_grp,
   input logic             code_err,
   input logic             sync_ok,
   input logic [ACQ_W-1:0] acq_cnt,
   input logic [ACQ_W-1:0] acq_lim,
   input logic [ERR_W-1:0] err_cnt,
   input logic [ERR_W-1:0] lose_lim,
   input logic [RUN_W-1:0] run_cnt,
   input logic [RUN_W-1:0] run_lim
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> !sync_ok);

   assert_rise_on_last_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_ok) |-> $past(word_vld && sync_grp && !code_err && acq_cnt == acq_lim));

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> $stable(sync_ok));

   assert_acq_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acq_cnt <= acq_lim);

   assert_error_restarts_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_ok && word_vld && code_err) |=> (acq_cnt == '0 && !sync_ok));

   assert_fall_on_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sync_ok) && $past(rst_n)) |-> $past(word_vld && code_err && err_cnt == lose_lim));

   assert_err_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt <= lose_lim);

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !code_err && err_cnt == '0) |=> err_cnt == '0);

   assert_run_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= run_lim);

   assert_hunt_clears_errors_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |=> (!sync_ok || err_cnt == '0));

endmodule

bind link_sync_tracker lsync_checker #(
   .ACQ_W (ACQ_W),
   .ERR_W (ERR_W),
   .RUN_W (RUN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .word_vld (word_vld),
   .sync_grp (sync_grp),
   .code_err (code_err),
   .sync_ok  (sync_ok),
   .acq_cnt  (acq_cnt),
   .acq_lim  (acq_lim),
   .err_cnt  (err_cnt),
   .lose_lim (lose_lim),
   .run_cnt  (run_cnt),
   .run_lim  (run_lim)
);

// File: tb/tb_link_sync_tracker.sv
module tb_link_sync_tracker;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] cfg_acq_m1;
   logic [7:0] cfg_lose_m1;
   logic [5:0] cfg_run_m1;
   logic       word_vld;
   logic       sync_grp;
   logic       code_err;
   logic       sync_ok;
   logic       sync_ok_pcie;
   logic [7:0] zero8 = 8'd0;
   logic [5:0] zero6 = 6'd0;

   always #4 clk = ~clk;

   link_sync_tracker dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_acq_m1  (cfg_acq_m1),
      .cfg_lose_m1 (cfg_lose_m1),
      .cfg_run_m1  (cfg_run_m1),
      .word_vld    (word_vld),
      .sync_grp    (sync_grp),
      .code_err    (code_err),
      .sync_ok     (sync_ok)
   );

   link_sync_tracker #(.MODE(1)) dut_pcie (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_acq_m1  (zero8),
      .cfg_lose_m1 (zero8),
      .cfg_run_m1  (zero6),
      .word_vld    (word_vld),
      .sync_grp    (sync_grp),
      .code_err    (code_err),
      .sync_ok     (sync_ok_pcie)
   );

   typedef struct {
      int    due;
      bit    pcie;
      bit    exp;
      string tag;
   } item_t;

   item_t q[$];
   int    cyc      = 0;
   int    total    = 0;
   int    bad      = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit act, bit exp, string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: sync_ok actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: compare each expected item in the cycle it is due
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(it.pcie ? sync_ok_pcie : sync_ok, it.exp, it.tag);
         end
      end
   end

   task automatic drive(bit v, bit s, bit e, bit pc, bit exp, string tag);
      @(negedge clk);
      word_vld = v;
      sync_grp = s;
      code_err = e;
      q.push_back('{due: cyc + 1, pcie: pc, exp: exp, tag: tag});
   endtask

   task automatic syncw(bit exp, string tag);  drive(1, 1, 0, 0, exp, tag); endtask
   task automatic errw(bit exp, string tag);   drive(1, 0, 1, 0, exp, tag); endtask
   task automatic goodw(bit exp, string tag);  drive(1, 0, 0, 0, exp, tag); endtask
   task automatic idlew(bit exp, string tag);  drive(0, 0, 0, 0, exp, tag); endtask

   task automatic do_reset(logic [7:0] a, logic [7:0] l, logic [5:0] r);
      @(negedge clk);
      rst_n       = 1'b0;
      word_vld    = 1'b0;
      sync_grp    = 1'b0;
      code_err    = 1'b0;
      cfg_acq_m1  = a;
      cfg_lose_m1 = l;
      cfg_run_m1  = r;
      repeat (2) @(negedge clk);
      check(sync_ok, 1'b0, "R1 in reset");
      check(sync_ok_pcie, 1'b0, "R1 in reset (preset)");
      rst_n = 1'b1;
      idlew(0, "R1 after release");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; word_vld = 1'b0; sync_grp = 1'b0; code_err = 1'b0;
      cfg_acq_m1 = 8'd3; cfg_lose_m1 = 8'd2; cfg_run_m1 = 6'd1;

      // N=4, M=3, K=2
      do_reset(8'd3, 8'd2, 6'd1);
      for (int i = 0; i < 3; i++) syncw(0, "R2 acquiring");
      idlew(0, "R2 idle ignored");
      goodw(0, "R3 plain word holds count");
      syncw(1, "R2 lock on 4th sync");

      // run restart on error, then loss
      errw(1, "R4 err1");
      goodw(1, "R5 run1");
      errw(1, "R5 err2 run cleared");
      goodw(1, "R5 run1 again");
      errw(0, "R4 loss at 3rd error");

      // reacquire after loss
      for (int i = 0; i < 3; i++) syncw(0, "R6 full count needed");
      syncw(1, "R6 relock");

      // saturation at zero, decrement, idle
      for (int i = 0; i < 4; i++) goodw(1, "R5 goods with no errors");
      errw(1, "R5 err1 after saturation");
      goodw(1, "R5 run1");
      goodw(1, "R5 decrement to 0");
      errw(1, "R5 err1");
      errw(1, "R5 err2");
      idlew(1, "R4 idle while locked");
      errw(0, "R5 loss at 3rd error");

      // fresh run after each decrement
      for (int i = 0; i < 3; i++) syncw(0, "R6 acquiring");
      syncw(1, "R6 relock");
      errw(1, "R5 err1");
      errw(1, "R5 err2");
      goodw(1, "R5 run1");
      goodw(1, "R5 dec to 1");
      goodw(1, "R5 run1 fresh");
      goodw(1, "R5 dec to 0");
      errw(1, "R5 err1");
      errw(1, "R5 err2");
      errw(0, "R4 loss");

      // error restarts acquisition
      do_reset(8'd3, 8'd2, 6'd1);
      for (int i = 0; i < 3; i++) syncw(0, "R3 acquiring");
      errw(0, "R3 error restarts");
      for (int i = 0; i < 3; i++) syncw(0, "R3 recount");
      drive(1, 1, 1, 0, 0, "R3 sync+err is error");
      for (int i = 0; i < 3; i++) syncw(0, "R3 recount 2");
      syncw(1, "R3 lock after restart");

      // minimum counts
      do_reset(8'd0, 8'd0, 6'd0);
      syncw(1, "R2 N=1 lock");
      errw(0, "R4 M=1 loss");

      // maximum acquire count
      do_reset(8'd255, 8'd2, 6'd1);
      for (int i = 0; i < 255; i++) syncw(0, "R2 N=256 acquiring");
      syncw(1, "R2 N=256 lock");

      // preset 4/17/16, ports tied to zero are ignored
      do_reset(8'd0, 8'd0, 6'd0);
      for (int i = 0; i < 3; i++) drive(1, 1, 0, 1, 0, "R7 preset acquiring");
      drive(1, 1, 0, 1, 1, "R7 preset lock on 4th");
      for (int i = 0; i < 16; i++) drive(1, 0, 1, 1, 1, "R7 preset 16 errors held");
      for (int i = 0; i < 15; i++) drive(1, 0, 0, 1, 1, "R7 preset run");
      drive(1, 0, 0, 1, 1, "R7 preset decrement at 16");
      drive(1, 0, 1, 1, 1, "R7 preset back to 16");
      drive(1, 0, 1, 1, 0, "R7 preset loss at 17");

      idlew(0, "R2 final idle");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule